// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns two general-purpose port inputs into interrupt request flags for a processor. Each channel picks one bit of an 8-bit input port and passes it through a two-flop synchronizer. It then applies a per-channel polarity and reports a request flag in one of two ways. In edge mode the flag is latched and stays set until the processor vectors to the handler or software rewrites it. In level mode the flag simply follows the input's active state.

The selected pin is only sampled and is never driven, so the same pin stays free for any other use. A configuration write to a channel holds off edge detection for a few cycles. During that time the synchronizer and the previous-value register settle on the new pin and polarity, so no false edge is reported.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset every pending output is 0. Every channel is configured as level mode, active low, watching port bit 0, and its synchronizer holds the idle (high) value.
- R2: Configuration word `cfg_wdata` is written to channel c when `cfg_we[c]` is 1. Bit 0 is polarity: 1 means active high and 0 means active low. Bit 1 is trigger mode: 1 means edge and 0 means level. Bits 4:2 give the port bit to watch.
- R3: A channel reacts only to the port bit named by its select field. Toggling any other port bit leaves its pending output unchanged.
- R4: Each pin passes two synchronizer flops. In level mode, a pin change present before clock edge j shows on `pending` after edge j+1. In edge mode, it sets `pending` after edge j+2.
- R5: In edge mode, a move of the pin from inactive to active sets the channel's flag. The flag stays set after the pin returns to inactive.
- R6: In edge mode, `irq_ack[c]` high at a clock edge clears the channel's flag.
- R7: In level mode, `pending[c]` is 1 exactly while the synchronized pin is active and is not latched. A pin that stays active keeps the request asserted, so a new request follows service. `irq_ack` and `flag_we` have no effect in level mode.
- R8: In edge mode, `flag_we[c]` high at a clock edge loads `flag_wdata[c]` into the flag, which can set it or clear it.
- R9: In edge mode, a hardware edge detected at the same clock edge as a software clear, an acknowledge, or both leaves the flag set.
- R10: A configuration write at edge k suppresses edge detection at edges k+1, k+2 and k+3. A change of pin or polarity alone therefore never sets the flag.
- R11: The two channels are independent. Traffic, writes and acknowledges on one channel never alter the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| port_in | input | 8 | Port input bits that the channels watch |
| cfg_we | input | 2 | Per-channel configuration write strobe |
| cfg_wdata | input | 5 | Configuration word {select[2:0], edge, polarity} |
| irq_ack | input | 2 | Per-channel vector acknowledge from the processor |
| flag_we | input | 2 | Per-channel software write strobe for the flag |
| flag_wdata | input | 2 | Per-channel value for a software flag write |
| pending | output | 2 | Per-channel interrupt request flag |

## Verification
In edge mode, a detected input edge can land on the same clock edge as a software clear or a vector acknowledge. Both of those try to clear the flag, while the edge tries to set it. The bench times a pin rise so that its detection falls exactly two edges after the change. It then raises a software clear and an acknowledge for that same edge, and expects the flag set afterwards. The same cycle-by-cycle model, which orders set after clear, judges every other cycle too. Configuration writes that meet an already-active pin test the second overlap, where a pin or polarity switch would otherwise look like an edge.

// File: rtl/eid_pkg.sv
package eid_pkg;
  localparam int PORT_W      = 8;
  localparam int SEL_W       = $clog2(PORT_W);
  localparam int SYNC_STAGES = 2;
  localparam int BLANK_CYC   = SYNC_STAGES + 1;
  localparam int BLANK_W     = $clog2(BLANK_CYC + 1);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             trig_edge;
    logic             pol;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/eid_cfg_reg.sv
module eid_cfg_reg
  import eid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q,
  output logic             blank
);
  cfg_t               cfg_d;
  logic [BLANK_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  assign cnt_en = we | (cnt_q != '0);
  assign blank  = (cnt_q != '0);

  always_comb begin
    cfg_d = cfg_q;
    cnt_d = cnt_q;
    if (we) begin
      cfg_d = cfg_t'(wdata);
      cnt_d = BLANK_W'(BLANK_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (we)     cfg_q <= cfg_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eid_pin_sync.sv
module eid_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  assign sh_d = {sh_q[STAGES-2:0], d};
  assign q    = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/eid_flag.sv
module eid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic trig_edge,
  input  logic blank,
  input  logic ack,
  input  logic swe,
  input  logic swd,
  output logic pending,
  output logic hit
);
  logic prev_q;
  logic pend_q, pend_d;

  assign hit = trig_edge & ~blank & act & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (!trig_edge) begin
      pend_d = 1'b0;
    end else begin
      if (ack) pend_d = 1'b0;
      if (swe) pend_d = swd;
      if (hit) pend_d = 1'b1;
    end
  end

  assign pending = trig_edge ? pend_q : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= act;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic [NCH-1:0]    cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [NCH-1:0]    irq_ack,
  input  logic [NCH-1:0]    flag_we,
  input  logic [NCH-1:0]    flag_wdata,
  output logic [NCH-1:0]    pending
);
  cfg_t           chan_cfg [NCH];
  logic [NCH-1:0] chan_blank;
  logic [NCH-1:0] chan_pin;
  logic [NCH-1:0] chan_sync;
  logic [NCH-1:0] chan_act;
  logic [NCH-1:0] chan_edge;
  logic [NCH-1:0] chan_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    eid_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we[g]),
      .wdata (cfg_wdata),
      .cfg_q (chan_cfg[g]),
      .blank (chan_blank[g])
    );

    assign chan_pin[g] = port_in[chan_cfg[g].sel];

    eid_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (chan_pin[g]),
      .q     (chan_sync[g])
    );

    assign chan_act[g]  = chan_cfg[g].pol ? chan_sync[g] : ~chan_sync[g];
    assign chan_edge[g] = chan_cfg[g].trig_edge;

    eid_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (chan_act[g]),
      .trig_edge (chan_edge[g]),
      .blank     (chan_blank[g]),
      .ack       (irq_ack[g]),
      .swe       (flag_we[g]),
      .swd       (flag_wdata[g]),
      .pending   (pending[g]),
      .hit       (chan_hit[g])
    );
  end
endmodule

// File: rtl/eid_checker.sv
module eid_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] cfg_we,
  input logic [NCH-1:0] irq_ack,
  input logic [NCH-1:0] flag_we,
  input logic [NCH-1:0] flag_wdata,
  input logic [NCH-1:0] pending,
  input logic [NCH-1:0] chan_edge,
  input logic [NCH-1:0] chan_hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_edge[i] && irq_ack[i] && !flag_we[i] && !chan_hit[i] && !cfg_we[i]) |=> !pending[i]); // R6
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_edge[i] && flag_we[i] && !chan_hit[i] && !cfg_we[i]) |=> (pending[i] == $past(flag_wdata[i]))); // R8
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_edge[i] && chan_hit[i] && !cfg_we[i]) |=> pending[i]); // R9
    AST_NO_CFG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we[i], 2) && !$past(flag_we[i]) && $past(chan_edge[i]) && chan_edge[i]) |-> !$rose(pending[i])); // R10
  end
endmodule

bind ext_irq_detect eid_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .irq_ack    (irq_ack),
  .flag_we    (flag_we),
  .flag_wdata (flag_wdata),
  .pending    (pending),
  .chan_edge  (chan_edge),
  .chan_hit   (chan_hit)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     port_in;
  logic [NCH-1:0] cfg_we, irq_ack, flag_we, flag_wdata;
  logic [4:0]     cfg_wdata;
  logic [NCH-1:0] pending;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ext_irq_detect #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .pending(pending)
  );

  // behavioural reference state
  int m_pol[NCH], m_edg[NCH], m_sel[NCH];
  int m_s1[NCH], m_s2[NCH], m_prev[NCH], m_pend[NCH], m_blank[NCH];

  function automatic int m_act(int c);
    return (m_pol[c] != 0) ? m_s2[c] : 1 - m_s2[c];
  endfunction

  function automatic int m_out(int c);
    return (m_edg[c] != 0) ? m_pend[c] : m_act(c);
  endfunction

  task automatic m_clear();
    for (int c = 0; c < NCH; c++) begin
      m_pol[c] = 0; m_edg[c] = 0; m_sel[c] = 0;
      m_s1[c] = 1; m_s2[c] = 1; m_prev[c] = 0; m_pend[c] = 0; m_blank[c] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int a, h;
        a = m_act(c);
        h = (m_edg[c] != 0 && m_blank[c] == 0 && a == 1 && m_prev[c] == 0) ? 1 : 0;
        if (m_edg[c] == 0) m_pend[c] = 0;
        else begin
          if (irq_ack[c]) m_pend[c] = 0;
          if (flag_we[c]) m_pend[c] = int'(flag_wdata[c]);
          if (h == 1)     m_pend[c] = 1;
        end
        m_prev[c] = a;
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(port_in[m_sel[c]]);
        if (cfg_we[c]) begin
          m_blank[c] = 3;
          m_pol[c] = int'(cfg_wdata[0]);
          m_edg[c] = int'(cfg_wdata[1]);
          m_sel[c] = int'(cfg_wdata[4:2]);
        end else if (m_blank[c] > 0) begin
          m_blank[c]--;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int c, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d t=%0t", tag, c, act_v, exp_v, $time);
    end
  endtask

  // model compared on every cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int c = 0; c < NCH; c++)
        check(int'(pending[c]) == m_out(c), (m_edg[c] != 0) ? "R5 edge model" : "R7 level model",
              c, int'(pending[c]), m_out(c));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pend(int c, int exp_v, string tag);
    check(int'(pending[c]) == exp_v, tag, c, int'(pending[c]), exp_v);
  endtask

  task automatic wr_cfg(int c, int sel, int edg, int pol);
    cfg_wdata  = {3'(sel), 1'(edg), 1'(pol)};
    cfg_we[c]  = 1'b1;
    tick(1);
    cfg_we     = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    m_clear();
    rst_n = 1'b0; port_in = 8'hFF; cfg_we = '0; cfg_wdata = '0;
    irq_ack = '0; flag_we = '0; flag_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_pend(0, 0, "R1 reset ch0");
    expect_pend(1, 0, "R1 reset ch1");

    // ch0: pin 3, edge, active high (pin already high); ch1: pin 5, level, active low
    wr_cfg(0, 3, 1, 1);
    wr_cfg(1, 5, 0, 0);
    tick(6);
    expect_pend(0, 0, "R10 active pin at config");
    port_in[3] = 1'b0; tick(4);
    expect_pend(0, 0, "R5 falling ignored");
    port_in[3] = 1'b1;
    tick(2);
    expect_pend(0, 0, "R4 edge latency not yet");
    tick(1);
    expect_pend(0, 1, "R5 rising sets");
    port_in[3] = 1'b0; tick(4);
    expect_pend(0, 1, "R5 latched");

    irq_ack[0] = 1'b1; tick(1); irq_ack = '0;
    expect_pend(0, 0, "R6 ack clears");
    flag_we[0] = 1'b1; flag_wdata[0] = 1'b1; tick(1); flag_we = '0;
    expect_pend(0, 1, "R8 sw set");
    flag_we[0] = 1'b1; flag_wdata[0] = 1'b0; tick(1); flag_we = '0;
    expect_pend(0, 0, "R8 sw clear");

    // R9: detection, sw clear and ack on the same edge
    port_in[3] = 1'b1; tick(2);
    flag_we[0] = 1'b1; flag_wdata[0] = 1'b0; irq_ack[0] = 1'b1;
    tick(1);
    flag_we = '0; irq_ack = '0;
    expect_pend(0, 1, "R9 hw set wins");
    port_in[3] = 1'b0; tick(3);
    irq_ack[0] = 1'b1; tick(1); irq_ack = '0;

    // R3: other pins toggled
    for (int b = 0; b < 8; b++) begin
      if (b != 3 && b != 5) begin
        port_in[b] = 1'b0; tick(1); port_in[b] = 1'b1; tick(1);
      end
    end
    tick(3);
    expect_pend(0, 0, "R3 other pins ignored");
    expect_pend(1, 0, "R11 ch1 untouched");

    // R7 level channel
    port_in[5] = 1'b0; tick(1);
    expect_pend(1, 0, "R4 level latency not yet");
    tick(1);
    expect_pend(1, 1, "R7 level active");
    expect_pend(0, 0, "R11 ch0 untouched");
    irq_ack[1] = 1'b1; flag_we[1] = 1'b1; flag_wdata[1] = 1'b0; tick(1);
    irq_ack = '0; flag_we = '0;
    expect_pend(1, 1, "R7 ack and write ignored");
    tick(5);
    expect_pend(1, 1, "R7 still requesting");
    port_in[5] = 1'b1; tick(2);
    expect_pend(1, 0, "R7 not latched");

    // R2: polarity swaps
    wr_cfg(0, 3, 1, 0);
    tick(6);
    expect_pend(0, 0, "R10 polarity swap no edge");
    port_in[3] = 1'b1; tick(3);
    expect_pend(0, 0, "R2 active low rise ignored");
    port_in[3] = 1'b0; tick(3);
    expect_pend(0, 1, "R2 active low fall sets");
    wr_cfg(1, 5, 0, 1);
    tick(3);
    expect_pend(1, 1, "R2 level active high");

    // R10: select change onto an active pin
    irq_ack[0] = 1'b1; tick(1); irq_ack = '0;
    port_in[3] = 1'b1; tick(4);
    port_in[6] = 1'b0;
    wr_cfg(0, 6, 1, 0);
    tick(6);
    expect_pend(0, 0, "R10 select change no edge");
    port_in[6] = 1'b1; tick(3);
    port_in[6] = 1'b0; tick(3);
    expect_pend(0, 1, "R10 edge after settle");

    // level then back to edge: flag starts clear
    wr_cfg(0, 6, 0, 0);
    tick(4);
    expect_pend(0, 1, "R7 level on active pin");
    wr_cfg(0, 6, 1, 0);
    tick(6);
    expect_pend(0, 0, "R10 re-entry to edge");

    done = 1;
    summary();
    $finish;
  end
endmodule